// File: doc/BRIEF.md
# Register Preload and Observability Controller

This block is the test-access logic for a bank of macrocells that each hold two state registers, a first-rank register (Q1) and a buried second-rank register (Q2). Under test, a preload mode lets a tester force known values into a chosen quarter of the registers. The quarter is picked by a bank select (Q1 or Q2) and a parity select (even or odd macrocells). A strobe then drives asynchronous set or clear controls built from a row of data bits. A second test mode routes the buried Q2 contents onto the macrocell outputs so that they can be observed.

The mode requests are logic-level signals, standing in for the high-voltage detectors of a real device. A security bit locks out both modes, and it does so in the same instant that it changes. The controller is purely combinational. Its load controls go straight to the asynchronous set and clear pins of the registers, so they never wait for a register clock. The output multiplexer selects go to the pin drivers.

Top module: `reg_preload_ctrl`

## Requirements
- R1: With no mode requested, all load controls are 0, every Q2 select is 0, `out_data_o` equals `q1_i`, and both activity flags are 0.
- R2: Register n is macrocell n/2, with bank n%2 (0 = Q1, 1 = Q2). A load targets the bank equal to `q_sel_i` in the macrocells whose index parity equals `odd_sel_i`. The encodings are 00 even Q1, 10 even Q2, 01 odd Q1, 11 odd Q2, written as {q_sel, odd_sel}.
- R3: A load drives exactly NUM_MC/2 registers. Macrocell m takes data bit m/2.
- R4: A data bit of 1 raises that register's set control, and 0 raises its clear control. Set and clear are never high together.
- R5: During a load, registers outside the selected group receive no set or clear.
- R6: Load controls are high only while preload is active and `pl_strobe_i` is high. With the strobe low, or with preload not requested, none are high.
- R7: In observe mode, `out_q2_sel_o[i]` equals `oe_i[i]`, and a selected output carries `q2_i[i]`.
- R8: Any output whose Q2 select is 0 carries `q1_i[i]`.
- R9: While `secure_i` is 1, no load controls, no Q2 selects and no activity flags are raised. Lifting the bit takes effect at once.
- R10: When preload and observe are both requested, preload wins: `pl_active_o` is 1, `obs_active_o` is 0 and all Q2 selects are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pl_mode_i | input | 1 | Preload mode request |
| obs_mode_i | input | 1 | Q2 observe mode request |
| secure_i | input | 1 | Security lock, blocks both modes |
| pl_strobe_i | input | 1 | Preload strobe, high loads |
| q_sel_i | input | 1 | Bank select, 0 = Q1, 1 = Q2 |
| odd_sel_i | input | 1 | Macrocell parity select, 1 = odd |
| pl_data_i | input | NUM_MC/2 | Preload data row |
| oe_i | input | NUM_MC | Per-output enable |
| q1_i | input | NUM_MC | Q1 register contents |
| q2_i | input | NUM_MC | Q2 register contents |
| pl_set_o | output | 2*NUM_MC | Asynchronous set per register |
| pl_clr_o | output | 2*NUM_MC | Asynchronous clear per register |
| pl_active_o | output | 1 | Preload mode granted |
| obs_active_o | output | 1 | Observe mode granted |
| out_q2_sel_o | output | NUM_MC | Output multiplexer picks Q2 |
| out_data_o | output | NUM_MC | Value routed to each output |

## Verification
On every input change, the assertions check the following: set and clear never overlap, a load touches exactly one quarter of the bank or nothing, the lock and preload priority suppress the Q2 selects, and a Q2 select never appears without its output enable. Only the bench scenarios show that the right quarter is hit for each select code, that each data bit lands on the correct macrocell, and that the output values follow Q1 or Q2 as expected.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

  typedef enum logic [1:0] {
    MODE_RUN     = 2'd0,
    MODE_PRELOAD = 2'd1,
    MODE_OBSERVE = 2'd2,
    MODE_LOCKED  = 2'd3
  } rpc_mode_e;

  // flat register index for macrocell mc, bank b (0 = first rank, 1 = buried)
  function automatic int reg_index(input int mc, input int bank);
    return 2 * mc + bank;
  endfunction

  // data lane feeding macrocell mc
  function automatic int lane_of(input int mc);
    return mc / 2;
  endfunction

  // does the select pair address macrocell mc, bank b
  function automatic logic target_hit(input logic q_sel, input logic odd_sel,
                                      input int mc, input int bank);
    logic bank_bit;
    logic par_bit;
    bank_bit = (bank % 2) != 0;
    par_bit  = (mc % 2) != 0;
    return (q_sel == bank_bit) && (odd_sel == par_bit);
  endfunction

endpackage

// File: rtl/rpc_mode_arb.sv
module rpc_mode_arb
  import rpc_pkg::*;
(
  input  logic      pl_req,
  input  logic      obs_req,
  input  logic      locked,
  input  logic      strobe,
  output rpc_mode_e mode,
  output logic      load_fire,
  output logic      pl_active,
  output logic      obs_active
);

  always_comb begin
    if (locked)       mode = MODE_LOCKED;
    else if (pl_req)  mode = MODE_PRELOAD;
    else if (obs_req) mode = MODE_OBSERVE;
    else              mode = MODE_RUN;
  end

  assign pl_active  = (mode == MODE_PRELOAD);
  assign obs_active = (mode == MODE_OBSERVE);
  assign load_fire  = pl_active & strobe;

endmodule

// File: rtl/rpc_load_decode.sv
module rpc_load_decode
  import rpc_pkg::*;
#(
  parameter  int NUM_MC  = 24,
  localparam int LANES   = NUM_MC / 2,
  localparam int NUM_REG = 2 * NUM_MC
) (
  input  logic               fire,
  input  logic               q_sel,
  input  logic               odd_sel,
  input  logic [LANES-1:0]   data,
  output logic [NUM_REG-1:0] set_ctl,
  output logic [NUM_REG-1:0] clr_ctl
);

  for (genvar mc = 0; mc < NUM_MC; mc++) begin : g_mc
    for (genvar bk = 0; bk < 2; bk++) begin : g_bank
      localparam int RI = reg_index(mc, bk);
      localparam int LN = lane_of(mc);
      logic hit;
      assign hit         = fire & target_hit(q_sel, odd_sel, mc, bk);
      assign set_ctl[RI] = hit &  data[LN];
      assign clr_ctl[RI] = hit & ~data[LN];
    end
  end

endmodule

// File: rtl/rpc_obs_mux.sv
module rpc_obs_mux #(
  parameter int NUM_MC = 24
) (
  input  logic              obs_on,
  input  logic [NUM_MC-1:0] oe,
  input  logic [NUM_MC-1:0] q1,
  input  logic [NUM_MC-1:0] q2,
  output logic [NUM_MC-1:0] sel_q2,
  output logic [NUM_MC-1:0] dout
);

  for (genvar i = 0; i < NUM_MC; i++) begin : g_pin
    assign sel_q2[i] = obs_on & oe[i];
    assign dout[i]   = sel_q2[i] ? q2[i] : q1[i];
  end

endmodule

// File: rtl/reg_preload_ctrl.sv
module reg_preload_ctrl
  import rpc_pkg::*;
#(
  parameter  int NUM_MC  = 24,
  localparam int LANES   = NUM_MC / 2,
  localparam int NUM_REG = 2 * NUM_MC
) (
  input  logic               pl_mode_i,
  input  logic               obs_mode_i,
  input  logic               secure_i,
  input  logic               pl_strobe_i,
  input  logic               q_sel_i,
  input  logic               odd_sel_i,
  input  logic [LANES-1:0]   pl_data_i,
  input  logic [NUM_MC-1:0]  oe_i,
  input  logic [NUM_MC-1:0]  q1_i,
  input  logic [NUM_MC-1:0]  q2_i,
  output logic [NUM_REG-1:0] pl_set_o,
  output logic [NUM_REG-1:0] pl_clr_o,
  output logic               pl_active_o,
  output logic               obs_active_o,
  output logic [NUM_MC-1:0]  out_q2_sel_o,
  output logic [NUM_MC-1:0]  out_data_o
);

  rpc_mode_e mode;
  logic      load_fire;

  rpc_mode_arb u_arb (
    .pl_req     (pl_mode_i),
    .obs_req    (obs_mode_i),
    .locked     (secure_i),
    .strobe     (pl_strobe_i),
    .mode       (mode),
    .load_fire  (load_fire),
    .pl_active  (pl_active_o),
    .obs_active (obs_active_o)
  );

  rpc_load_decode #(.NUM_MC(NUM_MC)) u_dec (
    .fire    (load_fire),
    .q_sel   (q_sel_i),
    .odd_sel (odd_sel_i),
    .data    (pl_data_i),
    .set_ctl (pl_set_o),
    .clr_ctl (pl_clr_o)
  );

  rpc_obs_mux #(.NUM_MC(NUM_MC)) u_mux (
    .obs_on (obs_active_o),
    .oe     (oe_i),
    .q1     (q1_i),
    .q2     (q2_i),
    .sel_q2 (out_q2_sel_o),
    .dout   (out_data_o)
  );

endmodule

// File: rtl/reg_preload_ctrl_chk.sv
module reg_preload_ctrl_chk #(
  parameter  int NUM_MC  = 24,
  localparam int NUM_REG = 2 * NUM_MC
) (
  input logic               secure_i,
  input logic               pl_strobe_i,
  input logic [NUM_MC-1:0]  oe_i,
  input logic [NUM_REG-1:0] pl_set_o,
  input logic [NUM_REG-1:0] pl_clr_o,
  input logic               pl_active_o,
  input logic               obs_active_o,
  input logic [NUM_MC-1:0]  out_q2_sel_o,
  input logic               load_fire
);

  always_comb begin
    p_set_clr_excl_r4: assert ((pl_set_o & pl_clr_o) == '0)
      else $error("set and clear overlap");
    p_quarter_count_r3: assert (($countones(pl_set_o | pl_clr_o) == 0) ||
                               ($countones(pl_set_o | pl_clr_o) == NUM_MC / 2))
      else $error("load width not one quarter");
    p_no_strobe_r6: assert (pl_strobe_i || ((pl_set_o | pl_clr_o) == '0))
      else $error("load without strobe");
    p_fire_matches_r6: assert (load_fire == ((pl_set_o | pl_clr_o) != '0))
      else $error("load controls disagree with fire");
    p_lock_r9: assert (!secure_i ||
                       (!pl_active_o && !obs_active_o && out_q2_sel_o == '0 &&
                        (pl_set_o | pl_clr_o) == '0))
      else $error("lock not honoured");
    p_priority_r10: assert (!pl_active_o || (!obs_active_o && out_q2_sel_o == '0))
      else $error("observe during preload");
    p_sel_oe_r7: assert ((out_q2_sel_o & ~oe_i) == '0)
      else $error("q2 select without enable");
  end

endmodule

bind reg_preload_ctrl reg_preload_ctrl_chk #(.NUM_MC(NUM_MC)) u_chk (.*);

// File: tb/reg_preload_ctrl_tb_top.sv
module reg_preload_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NMC  = 24;
  localparam int NL   = NMC / 2;
  localparam int NREG = 2 * NMC;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic            pl_mode, obs_mode, secure, strobe, q_sel, odd_sel;
  logic [NL-1:0]   data;
  logic [NMC-1:0]  oe, q1, q2;
  logic [NREG-1:0] set_o, clr_o;
  logic            pl_act, obs_act;
  logic [NMC-1:0]  sel_o, dout;

  reg_preload_ctrl #(.NUM_MC(NMC)) dut_i (
    .pl_mode_i(pl_mode), .obs_mode_i(obs_mode), .secure_i(secure),
    .pl_strobe_i(strobe), .q_sel_i(q_sel), .odd_sel_i(odd_sel),
    .pl_data_i(data), .oe_i(oe), .q1_i(q1), .q2_i(q2),
    .pl_set_o(set_o), .pl_clr_o(clr_o), .pl_active_o(pl_act),
    .obs_active_o(obs_act), .out_q2_sel_o(sel_o), .out_data_o(dout)
  );

  int n_run  = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent model of the load outputs
  task automatic model_load(output logic [NREG-1:0] es, output logic [NREG-1:0] ec);
    es = '0; ec = '0;
    for (int r = 0; r < NREG; r++) begin
      int m;
      bit sel;
      m   = r >> 1;
      sel = pl_mode && !secure && strobe && ((r & 1) == int'(q_sel)) &&
            ((m & 1) == int'(odd_sel));
      if (sel) begin
        if (data[m >> 1]) es[r] = 1'b1;
        else              ec[r] = 1'b1;
      end
    end
  endtask

  task automatic check_all(input string tag);
    logic [NREG-1:0] es, ec;
    logic [NMC-1:0]  esel, edat;
    model_load(es, ec);
    esel = (obs_mode && !pl_mode && !secure) ? oe : '0;
    edat = (q2 & esel) | (q1 & ~esel);
    check(set_o == es, {tag, " R2 R4 set"}, 64'(set_o), 64'(es));
    check(clr_o == ec, {tag, " R5 R4 clr"}, 64'(clr_o), 64'(ec));
    check(sel_o == esel, {tag, " R7 R10 sel"}, 64'(sel_o), 64'(esel));
    check(dout == edat, {tag, " R8 data"}, 64'(dout), 64'(edat));
    check(pl_act == (pl_mode && !secure), {tag, " R9 pl_act"}, 64'(pl_act),
          64'(pl_mode && !secure));
  endtask

  // {exp_count[3:0], pl, obs, sec, stb, q_sel, odd_sel, data[11:0]}
  localparam logic [21:0] VEC [16] = '{
    {4'd12, 6'b100100, 12'hA5C},
    {4'd12, 6'b100110, 12'h3F0},
    {4'd12, 6'b100101, 12'h001},
    {4'd12, 6'b100111, 12'h800},
    {4'd12, 6'b100100, 12'hFFF},
    {4'd12, 6'b100111, 12'h000},
    {4'd0,  6'b100000, 12'hFFF},
    {4'd0,  6'b000110, 12'hFFF},
    {4'd0,  6'b101100, 12'hABC},
    {4'd0,  6'b101111, 12'h123},
    {4'd12, 6'b110101, 12'h5A5},
    {4'd0,  6'b011100, 12'hFFF},
    {4'd0,  6'b010111, 12'h0F0},
    {4'd12, 6'b110110, 12'hC33},
    {4'd0,  6'b111111, 12'hFFF},
    {4'd0,  6'b000000, 12'h000}
  };

  task automatic apply_vec(input logic [21:0] v);
    {pl_mode, obs_mode, secure, strobe, q_sel, odd_sel} = v[17:12];
    data = v[11:0];
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    pl_mode = 0; obs_mode = 0; secure = 0; strobe = 0; q_sel = 0; odd_sel = 0;
    data = '0; oe = 24'hF0F00F; q1 = 24'hA5A5A5; q2 = 24'h3C3C3C;
    @(negedge clk);
    // R1 idle state
    check(set_o == '0 && clr_o == '0, "R1 idle loads", 64'(set_o | clr_o), 64'd0);
    check(dout == q1 && sel_o == '0, "R1 idle outputs", 64'(dout), 64'(q1));
    check(!pl_act && !obs_act, "R1 idle flags", 64'({pl_act, obs_act}), 64'd0);

    for (int i = 0; i < 16; i++) begin
      @(posedge clk);
      apply_vec(VEC[i]);
      @(negedge clk);
      check($countones(set_o | clr_o) == int'(VEC[i][21:18]), "R3 R6 count",
            64'($countones(set_o | clr_o)), 64'(VEC[i][21:18]));
      check_all("vec");
    end

    // R3 lane mapping: single bit lands on macrocell 2k+odd only
    for (int k = 0; k < NL; k += 5) begin
      @(posedge clk);
      pl_mode = 1; obs_mode = 0; secure = 0; strobe = 1; q_sel = 1; odd_sel = 1;
      data = NL'(1) << k;
      @(negedge clk);
      check(set_o == (NREG'(1) << (4 * k + 3)), "R3 lane map", 64'(set_o),
            64'(NREG'(1) << (4 * k + 3)));
    end

    // R7 observe with varied enables
    @(posedge clk);
    pl_mode = 0; obs_mode = 1; strobe = 0; oe = 24'h0FF0F1;
    @(negedge clk);
    check(sel_o == oe && obs_act, "R7 observe sel", 64'(sel_o), 64'(oe));
    check_all("R7");
    @(posedge clk);
    oe = '0;
    @(negedge clk);
    check(dout == q1, "R8 observe no oe", 64'(dout), 64'(q1));

    // R9 lock and unlock take effect at once
    @(posedge clk);
    oe = '1; pl_mode = 1; strobe = 1; q_sel = 0; odd_sel = 0; data = 12'hFFF;
    #1 secure = 1;
    #1 check(set_o == '0 && !pl_act, "R9 lock immediate", 64'(set_o), 64'd0);
    secure = 0;
    #1 check($countones(set_o) == NL, "R9 unlock immediate",
             64'($countones(set_o)), 64'(NL));
    @(negedge clk);
    // R10 priority
    check(pl_act && !obs_act && sel_o == '0, "R10 priority",
          64'({pl_act, obs_act}), 64'(2'b10));
    strobe = 0;
    #1 check(set_o == '0 && clr_o == '0, "R6 strobe low", 64'(set_o | clr_o), 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule